// File: doc/BRIEF.md
# Task-Driven Serial Port Control Core

This block is the register-level control core of a serial port that software drives through one-shot task writes and observes through sticky event flags. It decodes single-cycle 32-bit word-addressed bus accesses. It keeps a master enable, run flags for the transmitter and the receiver, an interrupt mask, four event flags, an error source register and a set of plain configuration registers. It drives one level-sensitive interrupt line.

Toward the outside it has two byte streams, both valid/ready. On the transmit side the block is the producer. A byte accepted from the bus is held on `tx_data` with `tx_valid` high until the shifter asserts `tx_ready`. A cycle where both are high completes the byte. While `tx_ready` is low, the byte and `tx_valid` hold steady, so the shifter may stall for as long as it needs. On the receive side the external byte buffer is the producer. It presents `rx_valid`/`rx_data`, and the block raises `rx_ready` for exactly the cycle in which software reads the receive data register while the port is enabled and the receiver is running. The buffer pops on that cycle. Pulses on `rx_arrive` and `line_break` report a byte landing in the buffer and a break on the line.

Top module: `tev_serial_ctrl`

## Requirements
- R1: After reset, with the port then enabled, the four pin-select registers (word addresses 0x34..0x37) read 0xFFFFFFFF, the baud register (0x3C) reads 0x04000000, and the interrupt mask, events, error source and config register (0x3D) read 0. `irq`, `tx_valid` and `rx_ready` are low.
- R2: A write of exactly 4 to the enable register (0x31) turns the port on. Any other nonzero value leaves the enable state unchanged. An enabled port reads 4 there.
- R3: While the port is off, every read returns 0 and every write to an address other than 0x31 has no effect.
- R4: Writing 0 to 0x31 turns the port off, stops the transmitter and the receiver, and sets the receive-timeout event.
- R5: The interrupt mask is written directly at 0x20, OR-ed with the written bits at 0x21, and cleared where written bits are 1 at 0x22. A read at any of the three returns the mask.
- R6: `irq` is high exactly when some event flag is set and its mask bit is set. The bit positions are 0 receive-ready, 1 transmit-ready, 2 error and 3 receive-timeout. The event registers are at 0x10+position and read back in bit 0.
- R7: The task registers act only on a written value of 1: start-receive 0x00, stop-receive 0x01, start-transmit 0x02, stop-transmit 0x03, suspend 0x04. Stop-receive clears the receiver run flag and sets receive-timeout. Stop-transmit clears only the transmitter run flag. Suspend clears both and sets receive-timeout.
- R8: A write to the transmit data register (0x33) is taken only when the transmitter is running and no byte is pending. The byte then stays on `tx_data` with `tx_valid` high until a cycle with `tx_ready` high. After that cycle `tx_valid` is low and the transmit-ready event is set.
- R9: The error source register (0x30) is write-one-to-clear. A `line_break` pulse sets its bits 1:0 and sets the error event.
- R10: A write to the transmit-ready, error or receive-timeout event stores 1 for a nonzero value and 0 for zero. The receive-ready event can only be cleared by writing 0; a nonzero write leaves it unchanged.
- R11: A read of 0x32 returns `rx_data`. `rx_ready` is high for that read only when the port is enabled, the receiver is running and `rx_valid` is high. If `rx_more` is high on that cycle, the receive-ready event is set again. An `rx_arrive` pulse sets the receive-ready event.
- R12: When a hardware event source and a software clear of the same flag fall in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Shifter takes the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive buffer holds a byte |
| rx_more | input | 1 | Receive buffer holds two or more bytes |
| rx_data | input | 8 | Head byte of the receive buffer |
| rx_ready | output | 1 | Pop strobe for the receive buffer |
| rx_arrive | input | 1 | Pulse: a byte entered the receive buffer |
| line_break | input | 1 | Pulse: break detected on the line |

## Verification
The hardest situations to reach from the pins are same-cycle collisions. One is a hardware source (break, transmit done, byte arrival) landing on the same edge as a software write that clears the same flag. Another is a new transmit write landing on the edge where the pending byte completes. The bench drives both the bus and the side pins at one falling edge, so they meet at a single rising edge, and then reads the flag back. Sweeps over every mask value against every event pattern, and over every small enable value, cover the gating and the magic-value decode.

// File: rtl/tev_pkg.sv
package tev_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_START_RX = 8'h00;
  localparam logic [ADDR_W-1:0] A_STOP_RX  = 8'h01;
  localparam logic [ADDR_W-1:0] A_START_TX = 8'h02;
  localparam logic [ADDR_W-1:0] A_STOP_TX  = 8'h03;
  localparam logic [ADDR_W-1:0] A_SUSPEND  = 8'h04;
  localparam logic [ADDR_W-1:0] A_EVT0     = 8'h10;
  localparam logic [ADDR_W-1:0] A_IE       = 8'h20;
  localparam logic [ADDR_W-1:0] A_IE_SET   = 8'h21;
  localparam logic [ADDR_W-1:0] A_IE_CLR   = 8'h22;
  localparam logic [ADDR_W-1:0] A_ERRSRC   = 8'h30;
  localparam logic [ADDR_W-1:0] A_ENABLE   = 8'h31;
  localparam logic [ADDR_W-1:0] A_RXDATA   = 8'h32;
  localparam logic [ADDR_W-1:0] A_TXDATA   = 8'h33;
  localparam logic [ADDR_W-1:0] A_PSEL0    = 8'h34;
  localparam logic [ADDR_W-1:0] A_BAUD     = 8'h3C;
  localparam logic [ADDR_W-1:0] A_CFG      = 8'h3D;

  localparam int N_EV     = 4;
  localparam int EV_RXRDY = 0;
  localparam int EV_TXRDY = 1;
  localparam int EV_ERR   = 2;
  localparam int EV_RXTO  = 3;

  localparam int unsigned ENABLE_KEY = 4;
  localparam logic [31:0] BAUD_RESET = 32'h0400_0000;
endpackage

// File: rtl/tev_tx_hold.sv
module tev_tx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              done
);
  logic              busy_q;
  logic [BYTE_W-1:0] byte_q;

  assign done     = busy_q & tx_ready;
  assign tx_valid = busy_q;
  assign tx_data  = byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      byte_q <= '0;
    end else begin
      if (done) busy_q <= 1'b0;
      else if (load) busy_q <= 1'b1;
      if (load && !busy_q) byte_q <= load_byte;
    end
  end
endmodule

// File: rtl/tev_irq_gate.sv
module tev_irq_gate #(
  parameter int N = 4
) (
  input  logic [N-1:0] ev,
  input  logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] hit;
  for (genvar i = 0; i < N; i++) begin : g_gate
    assign hit[i] = ev[i] & mask[i];
  end
  assign irq = |hit;
endmodule

// File: rtl/tev_regbank.sv
module tev_regbank
  import tev_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int NUM_PSEL = 4,
  parameter int ERR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_pending,
  input  logic              tx_done,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_valid,
  input  logic              rx_more,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_arrive,
  input  logic              line_break,
  output logic              enabled,
  output logic              tx_run,
  output logic              rx_run,
  output logic [N_EV-1:0]   ie,
  output logic [N_EV-1:0]   ev,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_load_byte,
  output logic              rx_pop
);
  logic wr, wr_ok, rd_ok, val_one, val_zero;
  logic en_on, en_off, stop_all;
  logic t_start_rx, t_stop_rx, t_start_tx, t_stop_tx, t_suspend;
  logic [N_EV-1:0]   hw_set;
  logic [ERR_W-1:0]  errsrc;
  logic [DATA_W-1:0] psel [NUM_PSEL];
  logic [DATA_W-1:0] baud, cfg;

  assign wr       = bus_valid & bus_we;
  assign wr_ok    = wr & (enabled | (bus_addr == A_ENABLE));
  assign rd_ok    = bus_valid & ~bus_we & enabled;
  assign val_one  = (bus_wdata == DATA_W'(1));
  assign val_zero = (bus_wdata == '0);

  assign en_on  = wr & (bus_addr == A_ENABLE) & (bus_wdata == DATA_W'(ENABLE_KEY));
  assign en_off = wr & (bus_addr == A_ENABLE) & val_zero;

  assign t_start_rx = wr_ok & (bus_addr == A_START_RX) & val_one;
  assign t_stop_rx  = wr_ok & (bus_addr == A_STOP_RX)  & val_one;
  assign t_start_tx = wr_ok & (bus_addr == A_START_TX) & val_one;
  assign t_stop_tx  = wr_ok & (bus_addr == A_STOP_TX)  & val_one;
  assign t_suspend  = wr_ok & (bus_addr == A_SUSPEND)  & val_one;
  assign stop_all   = t_suspend | en_off;

  assign tx_load      = wr_ok & (bus_addr == A_TXDATA) & tx_run & ~tx_pending;
  assign tx_load_byte = bus_wdata[BYTE_W-1:0];
  assign rx_pop       = rd_ok & (bus_addr == A_RXDATA) & rx_run & rx_valid;

  always_comb begin
    hw_set           = '0;
    hw_set[EV_RXRDY] = rx_arrive | (rx_pop & rx_more);
    hw_set[EV_TXRDY] = tx_done;
    hw_set[EV_ERR]   = line_break;
    hw_set[EV_RXTO]  = t_stop_rx | stop_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      tx_run  <= 1'b0;
      rx_run  <= 1'b0;
    end else begin
      if (en_on) enabled <= 1'b1;
      else if (en_off) enabled <= 1'b0;
      if (t_stop_tx | stop_all) tx_run <= 1'b0;
      else if (t_start_tx) tx_run <= 1'b1;
      if (t_stop_rx | stop_all) rx_run <= 1'b0;
      else if (t_start_rx) rx_run <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie <= '0;
    else if (wr_ok) begin
      if (bus_addr == A_IE) ie <= bus_wdata[N_EV-1:0];
      else if (bus_addr == A_IE_SET) ie <= ie | bus_wdata[N_EV-1:0];
      else if (bus_addr == A_IE_CLR) ie <= ie & ~bus_wdata[N_EV-1:0];
    end
  end

  for (genvar i = 0; i < N_EV; i++) begin : g_ev
    logic sw_hit, sw_take;
    assign sw_hit = wr_ok & (bus_addr == ADDR_W'(int'(A_EVT0) + i));
    if (i == EV_RXRDY) begin : g_clr_only
      assign sw_take = sw_hit & val_zero;
    end else begin : g_direct
      assign sw_take = sw_hit;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev[i] <= 1'b0;
      else if (hw_set[i]) ev[i] <= 1'b1;
      else if (sw_take) ev[i] <= ~val_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) errsrc <= '0;
    else begin
      logic [ERR_W-1:0] nxt;
      nxt = errsrc;
      if (wr_ok && bus_addr == A_ERRSRC) nxt = nxt & ~bus_wdata[ERR_W-1:0];
      if (line_break) nxt[1:0] = 2'b11;
      errsrc <= nxt;
    end
  end

  for (genvar i = 0; i < NUM_PSEL; i++) begin : g_psel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psel[i] <= '1;
      else if (wr_ok && bus_addr == ADDR_W'(int'(A_PSEL0) + i)) psel[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud <= DATA_W'(BAUD_RESET);
      cfg  <= '0;
    end else if (wr_ok) begin
      if (bus_addr == A_BAUD) baud <= bus_wdata;
      if (bus_addr == A_CFG)  cfg  <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (bus_addr)
        A_IE, A_IE_SET, A_IE_CLR: bus_rdata = DATA_W'(ie);
        A_ERRSRC: bus_rdata = DATA_W'(errsrc);
        A_ENABLE: bus_rdata = DATA_W'(ENABLE_KEY);
        A_RXDATA: bus_rdata = DATA_W'(rx_data);
        A_TXDATA: bus_rdata = DATA_W'(tx_byte);
        A_BAUD:   bus_rdata = baud;
        A_CFG:    bus_rdata = cfg;
        default:  bus_rdata = '0;
      endcase
      for (int i = 0; i < N_EV; i++)
        if (bus_addr == ADDR_W'(int'(A_EVT0) + i)) bus_rdata = DATA_W'(ev[i]);
      for (int i = 0; i < NUM_PSEL; i++)
        if (bus_addr == ADDR_W'(int'(A_PSEL0) + i)) bus_rdata = psel[i];
    end
  end
endmodule

// File: rtl/tev_serial_ctrl.sv
module tev_serial_ctrl
  import tev_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int NUM_PSEL = 4,
  parameter int ERR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic              rx_more,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rx_arrive,
  input  logic              line_break
);
  logic              enabled, tx_run, rx_run, tx_load, tx_done;
  logic [N_EV-1:0]   ie, ev;
  logic [BYTE_W-1:0] tx_load_byte;

  tev_regbank #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_PSEL(NUM_PSEL), .ERR_W(ERR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_pending(tx_valid), .tx_done(tx_done), .tx_byte(tx_data),
    .rx_valid(rx_valid), .rx_more(rx_more), .rx_data(rx_data),
    .rx_arrive(rx_arrive), .line_break(line_break),
    .enabled(enabled), .tx_run(tx_run), .rx_run(rx_run),
    .ie(ie), .ev(ev), .tx_load(tx_load), .tx_load_byte(tx_load_byte),
    .rx_pop(rx_ready)
  );

  tev_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_byte(tx_load_byte),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .done(tx_done)
  );

  tev_irq_gate #(.N(N_EV)) u_irq (.ev(ev), .mask(ie), .irq(irq));
endmodule

// File: rtl/tev_serial_ctrl_chk.sv
module tev_serial_ctrl_chk
  import tev_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              line_break,
  input logic              enabled,
  input logic              rx_run,
  input logic [N_EV-1:0]   ie
);
  p_enable_magic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr == A_ENABLE && !enabled &&
     bus_wdata != DATA_W'(ENABLE_KEY) && bus_wdata != '0) |=> !enabled);

  p_quiet_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && !enabled) |-> bus_rdata == '0);

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_tx_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  p_break_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_break && ie[EV_ERR] && !(bus_valid && bus_we)) |=> irq);

  p_pop_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (rx_valid && enabled && rx_run));
endmodule

bind tev_serial_ctrl tev_serial_ctrl_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .line_break(line_break),
  .enabled(enabled), .rx_run(rx_run), .ie(ie)
);

// File: tb/tev_serial_ctrl_test.sv
`timescale 1ns/1ps
module tev_serial_ctrl_test;
  import tev_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bv = 0, bw = 0, tx_ready = 0, rx_valid = 0, rx_more = 0, rx_arrive = 0, line_break = 0;
  logic [7:0] ba = '0, rx_data = 8'hC3;
  logic [31:0] bd = '0;
  logic [31:0] rdata;
  logic irq, tx_valid, rx_ready;
  logic [7:0] tx_data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tev_serial_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_we(bw), .bus_addr(ba),
    .bus_wdata(bd), .bus_rdata(rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_more(rx_more),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_arrive(rx_arrive), .line_break(line_break)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bv = 1; bw = 1; ba = a; bd = d;
    @(negedge clk); bv = 0; bw = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic pop);
    @(negedge clk); bv = 1; bw = 0; ba = a;
    #1 d = rdata; pop = rx_ready;
    @(negedge clk); bv = 0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d; logic p;
    rd(a, d, p);
    chk(tag, d, exp);
  endtask

  task automatic pulse_arrive();
    @(negedge clk); rx_arrive = 1; @(negedge clk); rx_arrive = 0;
  endtask

  task automatic clear_events();
    for (int i = 0; i < 4; i++) wr(A_EVT0 + 8'(i), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic p;
    repeat (3) @(negedge clk);
    // R1 reset outputs
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 0);
    rst_n = 1;
    // R3 disabled: reads zero, writes ignored
    rchk("R3 read psel", A_PSEL0, 0);
    wr(A_IE, 32'hF);
    wr(A_BAUD, 32'h1234);
    // R2 sweep of enable values
    for (int v = 0; v < 16; v++) begin
      wr(A_ENABLE, v);
      rchk("R2 enable sweep", A_PSEL0, (v == 4) ? 32'hFFFF_FFFF : 32'h0);
      wr(A_ENABLE, 0);
    end
    wr(A_ENABLE, 4);
    rchk("R2 enable readback", A_ENABLE, 4);
    wr(A_ENABLE, 7);
    rchk("R2 other value keeps on", A_ENABLE, 4);
    // R3 ignored writes left nothing behind
    rchk("R3 ie untouched", A_IE, 0);
    rchk("R3 baud untouched", A_BAUD, 32'h0400_0000);
    // R4 from repeated disables: receive-timeout set
    rchk("R4 rxto after disable", A_EVT0 + 3, 1);
    clear_events();
    // R1 reset values
    for (int i = 0; i < 4; i++) rchk("R1 psel", A_PSEL0 + 8'(i), 32'hFFFF_FFFF);
    rchk("R1 cfg", A_CFG, 0);
    rchk("R1 errsrc", A_ERRSRC, 0);
    for (int i = 0; i < 4; i++) rchk("R1 event", A_EVT0 + 8'(i), 0);
    // R5 mask alias sweep
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        wr(A_IE, a);
        wr(A_IE_SET, b);
        rchk("R5 set alias", A_IE_SET, a | b);
        wr(A_IE_CLR, b);
        rchk("R5 clr alias", A_IE_CLR, (a | b) & ~b & 32'hF);
        rchk("R5 direct", A_IE, (a | b) & ~b & 32'hF);
      end
    // R6 / R10 event x mask sweep
    for (int e = 0; e < 16; e++) begin
      clear_events();
      if (e[0]) pulse_arrive();
      for (int i = 1; i < 4; i++) if (e[i]) wr(A_EVT0 + 8'(i), 32'h80);
      for (int i = 0; i < 4; i++) rchk("R10 event direct", A_EVT0 + 8'(i), e[i]);
      for (int m = 0; m < 16; m++) begin
        wr(A_IE, m);
        chk("R6 irq gate", {31'b0, irq}, ((m & e) != 0) ? 1 : 0);
      end
    end
    wr(A_IE, 0);
    // R10 receive-ready: nonzero write does not clear or set
    clear_events(); pulse_arrive();
    wr(A_EVT0, 5);
    rchk("R10 rxrdy nonzero keeps", A_EVT0, 1);
    wr(A_EVT0, 0); wr(A_EVT0, 1);
    rchk("R10 rxrdy not settable", A_EVT0, 0);
    // R7 / R8 transmit
    wr(A_START_TX, 2);
    wr(A_TXDATA, 8'h5A);
    chk("R7 start needs one", {31'b0, tx_valid}, 0);
    wr(A_START_TX, 1);
    wr(A_TXDATA, 8'h5A);
    chk("R8 taken", {31'b0, tx_valid}, 1);
    chk("R8 data", {24'b0, tx_data}, 8'h5A);
    wr(A_TXDATA, 8'h33);
    repeat (3) @(negedge clk);
    chk("R8 held while pending", {24'b0, tx_data}, 8'h5A);
    rchk("R8 no done yet", A_EVT0 + 1, 0);
    // completion on same edge as a new write: write rejected
    @(negedge clk); tx_ready = 1; bv = 1; bw = 1; ba = A_TXDATA; bd = 8'h77;
    @(negedge clk); tx_ready = 0; bv = 0; bw = 0;
    chk("R8 done clears", {31'b0, tx_valid}, 0);
    rchk("R8 txrdy set", A_EVT0 + 1, 1);
    rchk("R8 byte kept", A_TXDATA, 8'h5A);
    wr(A_TXDATA, 8'h77);
    chk("R8 next taken", {24'b0, tx_data}, 8'h77);
    @(negedge clk); tx_ready = 1; @(negedge clk); tx_ready = 0;
    clear_events();
    wr(A_STOP_TX, 1);
    rchk("R7 stop_tx no rxto", A_EVT0 + 3, 0);
    wr(A_TXDATA, 8'h11);
    chk("R7 stop_tx stops", {31'b0, tx_valid}, 0);
    // R7 / R11 receive
    rx_valid = 1; rx_data = 8'hC3;
    rd(A_RXDATA, d, p);
    chk("R11 no pop before start", {31'b0, p}, 0);
    chk("R11 data", d, 8'hC3);
    wr(A_START_RX, 1);
    rd(A_RXDATA, d, p);
    chk("R11 pop", {31'b0, p}, 1);
    rchk("R11 rxrdy stays clear", A_EVT0, 0);
    rx_more = 1;
    rd(A_RXDATA, d, p);
    rchk("R11 rxrdy on more", A_EVT0, 1);
    rx_more = 0;
    rx_valid = 0;
    rd(A_RXDATA, d, p);
    chk("R11 no pop empty", {31'b0, p}, 0);
    rx_valid = 1;
    wr(A_STOP_RX, 3);
    rd(A_RXDATA, d, p);
    chk("R7 stop_rx needs one", {31'b0, p}, 1);
    rchk("R7 no rxto", A_EVT0 + 3, 0);
    wr(A_STOP_RX, 1);
    rd(A_RXDATA, d, p);
    chk("R7 stop_rx stops", {31'b0, p}, 0);
    rchk("R7 stop_rx rxto", A_EVT0 + 3, 1);
    clear_events();
    wr(A_START_RX, 1); wr(A_START_TX, 1);
    wr(A_SUSPEND, 1);
    rd(A_RXDATA, d, p);
    chk("R7 suspend rx", {31'b0, p}, 0);
    wr(A_TXDATA, 8'h22);
    chk("R7 suspend tx", {31'b0, tx_valid}, 0);
    rchk("R7 suspend rxto", A_EVT0 + 3, 1);
    // R4 disable stops both
    clear_events();
    wr(A_START_RX, 1); wr(A_START_TX, 1);
    wr(A_ENABLE, 0);
    rchk("R3 read while off", A_ENABLE, 0);
    wr(A_ENABLE, 4);
    rchk("R4 rxto", A_EVT0 + 3, 1);
    rd(A_RXDATA, d, p);
    chk("R4 rx stopped", {31'b0, p}, 0);
    wr(A_TXDATA, 8'h44);
    chk("R4 tx stopped", {31'b0, tx_valid}, 0);
    // R9 break and error source
    clear_events();
    @(negedge clk); line_break = 1; @(negedge clk); line_break = 0;
    rchk("R9 errsrc", A_ERRSRC, 3);
    rchk("R9 err event", A_EVT0 + 2, 1);
    wr(A_ERRSRC, 1);
    rchk("R9 w1c low", A_ERRSRC, 2);
    wr(A_ERRSRC, 2);
    rchk("R9 w1c high", A_ERRSRC, 0);
    // R12 collisions
    @(negedge clk); line_break = 1; bv = 1; bw = 1; ba = A_EVT0 + 2; bd = 0;
    @(negedge clk); line_break = 0; bv = 0; bw = 0;
    rchk("R12 break beats clear", A_EVT0 + 2, 1);
    @(negedge clk); line_break = 1; bv = 1; bw = 1; ba = A_ERRSRC; bd = 3;
    @(negedge clk); line_break = 0; bv = 0; bw = 0;
    rchk("R12 break beats w1c", A_ERRSRC, 3);
    @(negedge clk); rx_arrive = 1; bv = 1; bw = 1; ba = A_EVT0; bd = 0;
    @(negedge clk); rx_arrive = 0; bv = 0; bw = 0;
    rchk("R12 arrive beats clear", A_EVT0, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule